// File: doc/BRIEF.md
# Bulk Flash Block Programming Sequencer

This block is a host-side controller that fills one erase block of a parallel NOR flash with 16-bit words. It uses the device's streaming factory-program mode. A request gives a base address and a word count. The sequencer then writes the two-cycle entry command pair. It learns the device's state only by plain read cycles, never by a status command. Such a command would be taken as payload while the mode is active.

Data arrives on a valid/ready stream. The sequencer writes it in fixed-size chunks to consecutive addresses. When the real data runs out, the last chunk is filled with all-ones words. After every chunk it holds the stream off and stops writing until the device reports that its buffer is free. To leave the mode it writes an all-ones word into the neighbouring block. It then waits for the ready bit and judges the error bits of that final status.

Top module: `flash_bulk_streamer`

## Requirements
- R1: After reset, done, error, bus_we, bus_re and in_ready are all 0.
- R2: A start whose base address has any of its low log2(CHUNK_WORDS) bits set is rejected. So is a start whose word count exceeds the words left between the base and the end of its block. A rejected start issues no bus cycle, and done and error are both 1 in the cycle after start.
- R3: An accepted start first writes SETUP_CMD (0x0080) to the base address, then in the next cycle CONFIRM_CMD (0x00D0) to the base address, and then only issues reads.
- R4: Status comes only from plain reads, with rdata valid in the cycle after bus_re. No payload write is issued until a read returns bit 7 = 0 (mode active) and bit 0 = 0 (buffer free). bus_we and bus_re are never 1 together.
- R5: Stream words are written in arrival order, word n going to base + n, with bus_wdata equal to in_data in the accepting cycle.
- R6: Each chunk holds exactly CHUNK_WORDS writes. Once the real words are used up, the rest of the chunk is written with 0xFFFF.
- R7: After the last write of a chunk, no write of any kind is issued until a status read returns bit 0 = 0.
- R8: in_ready is 0 whenever the block is idle or polling, and no more than the requested count of words is ever accepted.
- R9: After the last chunk, the block writes 0xFFFF to the address formed from the base by clearing the in-block bits and inverting the lowest block-select bit. It then polls until a read returns bit 7 = 1.
- R10: That final read ends the run with a one-cycle done pulse. error equals bit 4 OR bit 3 OR bit 1 of it; bit 2 and other bits do not count.
- R11: If a read shows bit 7 = 1 with bit 4, 3 or 1 set while waiting to enter the mode, the run aborts with done and error. The same happens if bit 7 = 1 shows while waiting for the buffer. An abort issues no further write.
- R12: A word count of 0 writes no chunk; the exit write follows directly once the mode is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| start_base | input | ADDR_W | Word address of the first data word |
| start_len | input | LEN_W | Number of real words to program |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Result of the last run, held until the next accepted start |
| in_valid | input | 1 | Stream word present |
| in_ready | output | 1 | Stream word taken this cycle |
| in_data | input | DATA_W | Stream word |
| bus_addr | output | ADDR_W | Flash word address |
| bus_wdata | output | DATA_W | Flash write data |
| bus_we | output | 1 | Write cycle |
| bus_re | output | 1 | Read cycle |
| bus_rdata | input | DATA_W | Read data, valid the cycle after bus_re |

## Verification
A rejected start must show done and error in the first cycle after the start cycle, and the bench samples exactly there. Every other result depends on when the bench's device model changes status. The model returns read data one cycle after the read, and the bench waits for the done pulse, sampling mid-cycle after each falling edge. The full write sequence, the stream count and the error value are compared once done is seen. Bus ordering rules hold at every cycle, so they are counted cycle by cycle by the model as it observes each bus cycle.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_SETUP,
      S_CONFIRM,
      S_WAIT_ARM,
      S_FILL,
      S_WAIT_BUF,
      S_LEAVE,
      S_WAIT_LEAVE
   } seq_state_e;

   // status word bit positions, decoded by the device side as well
   localparam int unsigned STB_READY      = 7;
   localparam int unsigned STB_BUF_BUSY   = 0;
   localparam int unsigned STB_PROG_ERR   = 4;
   localparam int unsigned STB_SUPPLY_ERR = 3;
   localparam int unsigned STB_LOCK_ERR   = 1;

endpackage

// File: rtl/nbl_req_check.sv
module nbl_req_check #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned CHUNK_WORDS = 512,
   parameter int unsigned BLOCK_WORDS = 65536,
   parameter int unsigned LEN_W       = 17
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              reject_o
);
   localparam int unsigned CH_LOG2  = $clog2(CHUNK_WORDS);
   localparam int unsigned BLK_LOG2 = $clog2(BLOCK_WORDS);

   logic             aligned;
   logic [LEN_W-1:0] offs;
   logic [LEN_W-1:0] room;

   generate
      if (CH_LOG2 == 0) begin : g_any_align
         assign aligned = 1'b1;
      end else begin : g_mask_align
         assign aligned = (base_i[CH_LOG2-1:0] == '0);
      end
   endgenerate

   assign offs     = {1'b0, base_i[BLK_LOG2-1:0]};
   assign room     = LEN_W'(BLOCK_WORDS) - offs;
   assign reject_o = !aligned || (len_i > room);

   wire unused_base = ^base_i;

endmodule

// File: rtl/nbl_word_track.sv
module nbl_word_track #(
   parameter int unsigned CHUNK_WORDS = 512,
   parameter int unsigned LEN_W       = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             beat_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             pad_o,
   output logic             chunk_end_o,
   output logic [LEN_W-1:0] offset_o
);
   localparam int unsigned CH_LOG2 = $clog2(CHUNK_WORDS);
   localparam int unsigned CH_W    = (CH_LOG2 > 0) ? CH_LOG2 : 1;

   logic [CH_W-1:0]  widx;
   logic [LEN_W-1:0] wcount;

   assign chunk_end_o = (widx == CH_W'(CHUNK_WORDS - 1));
   assign pad_o       = (wcount >= len_i);
   assign offset_o    = wcount;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx   <= '0;
         wcount <= '0;
      end else if (clr_i) begin
         widx   <= '0;
         wcount <= '0;
      end else if (beat_i) begin
         wcount <= wcount + LEN_W'(1);
         widx   <= chunk_end_o ? '0 : widx + CH_W'(1);
      end
   end

endmodule

// File: rtl/nbl_status_eval.sv
module nbl_status_eval
   import nbl_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] rdata_i,
   output logic              arm_ok_o,
   output logic              buf_free_o,
   output logic              dev_ready_o,
   output logic              fault_o
);
   assign dev_ready_o = rdata_i[STB_READY];
   assign buf_free_o  = !rdata_i[STB_BUF_BUSY];
   assign arm_ok_o    = !rdata_i[STB_READY] && !rdata_i[STB_BUF_BUSY];
   assign fault_o     = rdata_i[STB_PROG_ERR] | rdata_i[STB_SUPPLY_ERR]
                      | rdata_i[STB_LOCK_ERR];

   wire unused_rd = ^rdata_i;

endmodule

// File: rtl/flash_bulk_streamer.sv
module flash_bulk_streamer
   import nbl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CHUNK_WORDS = 512,
   parameter int unsigned BLOCK_WORDS = 65536,
   parameter logic [DATA_W-1:0] SETUP_CMD   = 'h0080,
   parameter logic [DATA_W-1:0] CONFIRM_CMD = 'h00D0,
   localparam int unsigned LEN_W = $clog2(BLOCK_WORDS) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_base,
   input  logic [LEN_W-1:0]  start_len,
   output logic              done,
   output logic              error,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned CH_LOG2  = $clog2(CHUNK_WORDS);
   localparam int unsigned BLK_LOG2 = $clog2(BLOCK_WORDS);

   // elaboration-time parameter checks
   generate
      if ((1 << CH_LOG2) != CHUNK_WORDS) begin : g_bad_chunk
         $error("CHUNK_WORDS must be a power of two");
      end
      if ((1 << BLK_LOG2) != BLOCK_WORDS) begin : g_bad_block
         $error("BLOCK_WORDS must be a power of two");
      end
      if (BLOCK_WORDS <= CHUNK_WORDS) begin : g_bad_ratio
         $error("BLOCK_WORDS must exceed CHUNK_WORDS");
      end
      if (ADDR_W <= BLK_LOG2) begin : g_bad_addr
         $error("ADDR_W must cover more than one block");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold the status byte");
      end
   endgenerate

   seq_state_e        state;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q;
   logic              rd_pend;
   logic              done_q;
   logic              err_q;

   logic              reject;
   logic              pad;
   logic              chunk_end;
   logic [LEN_W-1:0]  offset;
   logic              arm_ok, buf_free, dev_ready, fault;
   logic              polling, sample, beat, accept;
   logic [ADDR_W-1:0] exit_addr;

   nbl_req_check #(
      .ADDR_W     (ADDR_W),
      .CHUNK_WORDS(CHUNK_WORDS),
      .BLOCK_WORDS(BLOCK_WORDS),
      .LEN_W      (LEN_W)
   ) u_req (
      .base_i  (start_base),
      .len_i   (start_len),
      .reject_o(reject)
   );

   nbl_word_track #(
      .CHUNK_WORDS(CHUNK_WORDS),
      .LEN_W      (LEN_W)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (accept),
      .beat_i     (beat),
      .len_i      (len_q),
      .pad_o      (pad),
      .chunk_end_o(chunk_end),
      .offset_o   (offset)
   );

   nbl_status_eval #(
      .DATA_W(DATA_W)
   ) u_stat (
      .rdata_i    (bus_rdata),
      .arm_ok_o   (arm_ok),
      .buf_free_o (buf_free),
      .dev_ready_o(dev_ready),
      .fault_o    (fault)
   );

   assign accept  = (state == S_IDLE) && start && !reject;
   assign polling = (state == S_WAIT_ARM) || (state == S_WAIT_BUF)
                 || (state == S_WAIT_LEAVE);
   assign sample  = polling && rd_pend;
   assign beat    = (state == S_FILL) && (pad || in_valid);

   always_comb begin
      exit_addr                 = base_q;
      exit_addr[BLK_LOG2-1:0]   = '0;
      exit_addr[BLK_LOG2]       = ~base_q[BLK_LOG2];
   end

   assign in_ready = (state == S_FILL) && !pad;
   assign bus_re   = polling && !rd_pend;
   assign bus_we   = (state == S_SETUP) || (state == S_CONFIRM)
                  || (state == S_LEAVE) || beat;
   assign done     = done_q;
   assign error    = err_q;

   always_comb begin
      bus_addr  = base_q;
      bus_wdata = '0;
      unique case (state)
         S_SETUP:   bus_wdata = SETUP_CMD;
         S_CONFIRM: bus_wdata = CONFIRM_CMD;
         S_FILL: begin
            bus_addr  = base_q + ADDR_W'(offset);
            bus_wdata = pad ? '1 : in_data;
         end
         S_LEAVE: begin
            bus_addr  = exit_addr;
            bus_wdata = '1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         base_q  <= '0;
         len_q   <= '0;
         rd_pend <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         rd_pend <= polling ? !rd_pend : 1'b0;
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  base_q <= start_base;
                  len_q  <= start_len;
                  if (reject) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     err_q <= 1'b0;
                     state <= S_SETUP;
                  end
               end
            end
            S_SETUP:   state <= S_CONFIRM;
            S_CONFIRM: state <= S_WAIT_ARM;
            S_WAIT_ARM: begin
               if (sample) begin
                  if (arm_ok) begin
                     state <= pad ? S_LEAVE : S_FILL;
                  end else if (dev_ready && fault) begin
                     state  <= S_IDLE;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end
               end
            end
            S_FILL: begin
               if (beat && chunk_end) state <= S_WAIT_BUF;
            end
            S_WAIT_BUF: begin
               if (sample) begin
                  if (dev_ready) begin
                     state  <= S_IDLE;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else if (buf_free) begin
                     state <= pad ? S_LEAVE : S_FILL;
                  end
               end
            end
            S_LEAVE: state <= S_WAIT_LEAVE;
            S_WAIT_LEAVE: begin
               if (sample && dev_ready) begin
                  state  <= S_IDLE;
                  done_q <= 1'b1;
                  err_q  <= fault;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nbl_checker.sv
module nbl_checker
   import nbl_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned CHUNK_WORDS = 512,
   parameter logic [DATA_W-1:0] SETUP_CMD = 'h0080
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              reject,
   input logic              done,
   input logic              error,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              bus_we,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input seq_state_e        state
);
   localparam int unsigned CH_LOG2 = $clog2(CHUNK_WORDS);
   localparam int unsigned CH_W    = (CH_LOG2 > 0) ? CH_LOG2 : 1;

   logic            re_q;
   logic            blocked;
   logic [CH_W-1:0] fill_cnt;
   logic            fill_wr;

   assign fill_wr = bus_we && (state == S_FILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_q     <= 1'b0;
         blocked  <= 1'b0;
         fill_cnt <= '0;
      end else begin
         re_q <= bus_re;
         if (done) begin
            blocked  <= 1'b0;
            fill_cnt <= '0;
         end else begin
            if (fill_wr) begin
               fill_cnt <= (fill_cnt == CH_W'(CHUNK_WORDS - 1)) ? '0
                                                                : fill_cnt + CH_W'(1);
            end
            if (fill_wr && fill_cnt == CH_W'(CHUNK_WORDS - 1)) blocked <= 1'b1;
            else if (re_q && !bus_rdata[STB_BUF_BUSY])          blocked <= 1'b0;
         end
      end
   end

   // R1: nothing moves on the bus or the stream while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE) |-> (!bus_we && !bus_re && !in_ready));

   // R2
   p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && start && reject) |=> (done && error && !bus_we && !bus_re));

   // R3
   p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && start && !reject) |=> (bus_we && bus_wdata == SETUP_CMD));

   // R4
   p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));

   // R5
   p_stream_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (bus_we && bus_wdata == in_data));

   // R7
   p_hold_after_chunk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> !bus_we);

   // R8
   p_no_ready_polling_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re |-> !in_ready);

   // R10
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: error only changes at the end of a run or when a run is accepted
   p_error_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !(state == S_IDLE && start)) |=> (error == $past(error) || done));

endmodule

bind flash_bulk_streamer nbl_checker #(
   .DATA_W     (DATA_W),
   .CHUNK_WORDS(CHUNK_WORDS),
   .SETUP_CMD  (SETUP_CMD)
) u_nbl_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .reject   (reject),
   .done     (done),
   .error    (error),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_data  (in_data),
   .bus_we   (bus_we),
   .bus_re   (bus_re),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .state    (state)
);

// File: tb/tb_flash_bulk_streamer.sv
module tb_flash_bulk_streamer;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int CW = 8;
   localparam int BW = 64;
   localparam int LW = 7;

   localparam int FM_NONE  = 0;
   localparam int FM_SETUP = 1;
   localparam int FM_BUF   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_base = '0;
   logic [LW-1:0] start_len = '0;
   logic          done, error, in_ready, bus_we, bus_re;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata = '0;

   always #4 clk = ~clk;

   flash_bulk_streamer #(
      .ADDR_W(AW), .DATA_W(DW), .CHUNK_WORDS(CW), .BLOCK_WORDS(BW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
      .start_len(start_len), .done(done), .error(error), .in_valid(in_valid),
      .in_ready(in_ready), .in_data(in_data), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .bus_rdata(bus_rdata)
   );

   int checks = 0;
   int errors = 0;

   // device model and observation state
   int            fm;
   logic [7:0]    final_bits;
   logic          mode_on, setup_seen, leaving, ready_back;
   logic [7:0]    st, st_next;
   int            busy, fill_n;
   int            viol_busy, viol_ready;
   int            wr_n, rd_n;
   logic [AW-1:0] wr_addr [0:255];
   logic [DW-1:0] wr_data [0:255];
   logic [DW-1:0] stream [0:63];
   int            cur_len, sent_idx, gap_pct;
   logic          stream_en = 1'b0;
   logic [AW-1:0] cur_base;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // stream driver
   always begin
      @(negedge clk);
      in_valid = stream_en && (sent_idx < cur_len) && (($urandom % 100) >= gap_pct);
      in_data  = (sent_idx < 64) ? stream[sent_idx] : '0;
   end

   // device model: observes each bus cycle mid-cycle, read data follows a cycle later
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         if (bus_re) begin
            rd_n++;
            bus_rdata = {8'h00, st};
            if (in_ready) viol_ready++;
         end
         if (bus_we) begin
            if (wr_n < 256) begin
               wr_addr[wr_n] = bus_addr;
               wr_data[wr_n] = bus_wdata;
            end
            wr_n++;
            if (!mode_on) begin
               if (bus_wdata == 16'h0080) setup_seen = 1'b1;
               else if (setup_seen && bus_wdata == 16'h00D0) begin
                  setup_seen = 1'b0;
                  mode_on    = (fm != FM_SETUP);
                  st         = 8'h80;
                  busy       = 3 + int'($urandom % 4);
                  st_next    = (fm == FM_SETUP) ? 8'h90 : 8'h00;
               end
            end else begin
               if (st[0] || st[7]) viol_busy++;
               if (bus_addr[AW-1:6] != cur_base[AW-1:6]) begin
                  mode_on = 1'b0;
                  leaving = 1'b1;
                  busy    = 2 + int'($urandom % 5);
                  st_next = 8'h80 | final_bits;
               end else begin
                  fill_n++;
                  if (fill_n == CW) begin
                     fill_n  = 0;
                     st      = 8'h01;
                     busy    = 2 + int'($urandom % 6);
                     st_next = (fm == FM_BUF) ? 8'h90 : 8'h00;
                     if (fm == FM_BUF) mode_on = 1'b0;
                  end
               end
            end
         end
         if (in_valid && in_ready) sent_idx++;
         if (busy > 0) begin
            busy--;
            if (busy == 0) begin
               st = st_next;
               if (leaving) ready_back = 1'b1;
            end
         end
      end
   end

   function automatic logic [AW+DW-1:0] exp_word(input int k, input logic [AW-1:0] b,
                                                 input int len);
      int padded = ((len + CW - 1) / CW) * CW;
      logic [AW-1:0] ex = (b & ~AW'(BW - 1)) ^ AW'(BW);
      if (k == 0) return {b, 16'h0080};
      if (k == 1) return {b, 16'h00D0};
      if (k - 2 < padded)
         return {b + AW'(k - 2), (k - 2 < len) ? stream[k-2] : 16'hFFFF};
      return {ex, 16'hFFFF};
   endfunction

   task automatic run(input logic [AW-1:0] b, input int len, input int mode,
                      input logic [7:0] bits, input logic exp_rej, input int gap);
      int   padded = ((len + CW - 1) / CW) * CW;
      int   exp_wr, lat, mism, room;
      logic got, err_seen, exp_err;
      room = BW - int'(b % BW);
      fm = mode; final_bits = bits; gap_pct = gap;
      mode_on = 0; setup_seen = 0; leaving = 0; ready_back = 0;
      st = 8'h80; st_next = 8'h80; busy = 0; fill_n = 0;
      viol_busy = 0; viol_ready = 0; wr_n = 0; rd_n = 0; sent_idx = 0;
      cur_len = (len > room) ? room : len;
      cur_base = b;
      for (int i = 0; i < 64; i++) stream[i] = DW'($urandom);
      @(negedge clk);
      start = 1'b1; start_base = b; start_len = LW'(len); stream_en = 1'b1;
      @(negedge clk);
      start = 1'b0;
      got = 0; lat = -1; err_seen = 0;
      for (int c = 0; c < 3000 && !got; c++) begin
         #2;
         if (done) begin got = 1; lat = c; err_seen = error; end
         else @(negedge clk);
      end
      stream_en = 1'b0;
      if (exp_rej) begin
         exp_wr = 0; exp_err = 1;
      end else if (mode == FM_SETUP) begin
         exp_wr = 2; exp_err = 1;
      end else if (mode == FM_BUF) begin
         exp_wr = 2 + CW; exp_err = 1;
      end else begin
         exp_wr = 3 + padded; exp_err = |(bits & 8'h1A);
      end
      chk(got, "R10 done pulse seen", int'(got), 1);
      chk(err_seen == exp_err, "R10/R11 error value", int'(err_seen), int'(exp_err));
      chk(wr_n == exp_wr, "R6/R9 write count", wr_n, exp_wr);
      mism = 0;
      for (int k = 0; k < exp_wr && k < wr_n && k < 256; k++)
         if ({wr_addr[k], wr_data[k]} != exp_word(k, b, len)) mism++;
      chk(mism == 0, "R3/R5/R6/R9 write sequence mismatches", mism, 0);
      chk(viol_busy == 0, "R4/R7 writes while device busy", viol_busy, 0);
      chk(viol_ready == 0, "R8 in_ready while polling", viol_ready, 0);
      if (exp_rej) begin
         chk(lat == 0, "R2 reject latency", lat, 0);
         chk(rd_n == 0, "R2 no read on reject", rd_n, 0);
      end else if (mode == FM_NONE) begin
         chk(sent_idx == len, "R8 words accepted", sent_idx, len);
         chk(ready_back, "R9 done only after ready", int'(ready_back), 1);
      end else if (mode == FM_BUF) begin
         chk(sent_idx <= CW, "R11 no words after abort", sent_idx, CW);
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed_val;
      seed_val = int'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      #2;
      chk(!done && !error && !bus_we && !bus_re && !in_ready, "R1 reset outputs",
          int'({done, error, bus_we, bus_re, in_ready}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(!done && !bus_we && !bus_re && !in_ready, "R1 idle after reset",
          int'({done, bus_we, bus_re, in_ready}), 0);

      // directed corner cases
      run(12'h103, 4, FM_NONE, 8'h00, 1'b1, 0);   // R2 misaligned base
      run(12'h038, 9, FM_NONE, 8'h00, 1'b1, 0);   // R2 too long for the block
      run(12'h038, 8, FM_NONE, 8'h00, 1'b0, 10);  // R6 exactly the room left
      run(12'h040, 16, FM_NONE, 8'h00, 1'b0, 30); // R6 whole chunks, no padding
      run(12'h080, 0, FM_NONE, 8'h00, 1'b0, 0);   // R12 zero words
      run(12'h0C8, 1, FM_NONE, 8'h00, 1'b0, 0);   // R6 one word, seven pads
      run(12'h100, 5, FM_SETUP, 8'h00, 1'b0, 0);  // R11 entry fault
      run(12'h140, 20, FM_BUF, 8'h00, 1'b0, 20);  // R11 abort during buffer wait
      run(12'h180, 3, FM_NONE, 8'h10, 1'b0, 0);   // R10 bit 4
      run(12'h1C0, 3, FM_NONE, 8'h08, 1'b0, 0);   // R10 bit 3
      run(12'h200, 3, FM_NONE, 8'h02, 1'b0, 0);   // R10 bit 1
      run(12'h240, 3, FM_NONE, 8'h04, 1'b0, 0);   // R10 bit 2 is not an error

      // constrained random runs
      for (int r = 0; r < 14; r++) begin
         logic [AW-1:0] b;
         int            room, len;
         b    = AW'(($urandom % ((1 << AW) / CW)) * CW);
         room = BW - int'(b % BW);
         len  = int'($urandom % (room + 1));
         run(b, len, FM_NONE, 8'h1E & 8'($urandom), 1'b0, int'($urandom % 50));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule